// File: doc/BRIEF.md
# Flash Command Interface Controller

This block sits between a synchronous host bus and a byte-wide boot-block flash array. It interprets bus writes as command codes, some complete in one write and some requiring a setup write followed by a second write, and it decides where each bus read is served from: the array, a status byte or a pair of identifier bytes. Program and block-erase operations are handed to a write engine. Erase can be suspended and resumed. A double Read Array command aborts an operation in progress.

For modelling purposes the array is a small internal byte memory, and the true program or erase duration is replaced by a busy counter of `BUSY_CYC` cycles. The array is organised in `2**BLK_W` equal blocks selected by the upper `BLK_W` address bits.

The command FSM has the states READY (accepting commands), PGM_WAIT (program setup seen, awaiting data), ERS_WAIT (erase setup seen, awaiting confirm), ERS_FAIL (erase setup was followed by Read Array), RUN (engine active) and SUSP (erase suspended). Its transitions are:
- READY→PGM_WAIT on 40h.
- READY→ERS_WAIT on 20h.
- PGM_WAIT→RUN on the data write.
- ERS_WAIT→RUN on D0h at the same block.
- ERS_WAIT→ERS_FAIL on FFh.
- ERS_WAIT→READY on any other write.
- ERS_FAIL→READY on any write other than D0h, which is then decoded as in READY.
- RUN→READY when the engine finishes or on a second consecutive FFh.
- RUN→SUSP on B0h during an erase.
- SUSP→RUN on D0h.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, reads return array data, every array byte reads FFh, and the status byte reads 80h.
- R2: A write of FFh while idle selects array data for subsequent reads.
- R3: A write of 90h selects identifier reads. Address bit 0 alone is decoded: 0 returns `MFR_CODE`, 1 returns `DEV_CODE`, and the other address bits are ignored.
- R4: A write of 70h selects status reads. The status byte layout is: bit 7 ready (1 = idle or suspended), bit 6 erase suspended, bit 5 erase error, bit 4 program error, bits 3..0 zero. Read data appears on `rdata` with `rvalid` high in the cycle after `rd_en`.
- R5: Programming is 40h at an address followed by a data write at that address. After `BUSY_CYC` cycles the stored byte becomes old AND new.
- R6: Erase is 20h followed by D0h, both with an address in the same block. When the counter expires, every byte of that block reads FFh and other blocks are unchanged.
- R7: Once a two-write sequence starts the engine, reads return the status byte until a Read Array command. Bit 7 is 0 while the engine runs and 1 after it completes.
- R8: FFh written in place of the erase confirm sets bits 5 and 4, starts no erase, and causes a following D0h to be ignored. Reads still return status until a further FFh selects the array.
- R9: A write of 50h while idle clears status bits 5 and 4.
- R10: Two consecutive FFh writes while the engine runs abort it. The target is left unmodified, the block is ready, and array reads are selected.
- R11: B0h during an erase freezes the counter and sets bits 6 and 7. D0h resumes the erase, clears bit 6, and the erase then completes. FFh while suspended selects array reads of the unerased data.
- R12: Unassigned codes written while idle change nothing, including the read source.
- R13: While the engine runs, every command except 70h, B0h (erase only) and the double FFh abort is ignored.
- R14: An erase setup followed by any write other than FFh or a same-block D0h sets bit 5 only, starts no erase, and leaves status reads selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| rd_en | input | 1 | Bus read strobe |
| addr | input | ADDR_W | Byte address for reads and writes |
| wdata | input | 8 | Write data or command code |
| rdata | output | 8 | Read data, registered |
| rvalid | output | 1 | Marks `rdata` valid, one cycle after `rd_en` |

## Verification
The assertions check, on every cycle, the protocol relations that hold regardless of the command sequence. Reads answer one cycle later. The engine starts only from a bus write. The read source is the status byte whenever the engine runs. Clear and unconfirmed-erase writes update the error bits. Suspend only happens over a running erase. The bench scenarios are needed for what depends on data and history: AND-programming, block-selective erase, identifier decoding, abort that leaves the target untouched, a frozen counter during suspend, and codes that are silently ignored.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        CMD_READY,
        CMD_PGM_WAIT,
        CMD_ERS_WAIT,
        CMD_ERS_FAIL,
        CMD_RUN,
        CMD_SUSP
    } cmd_state_t;

    typedef enum logic [1:0] {
        RD_ARRAY,
        RD_STATUS,
        RD_IDENT
    } rd_mode_t;

    localparam logic [7:0] OP_ARRAY   = 8'hFF;
    localparam logic [7:0] OP_IDENT   = 8'h90;
    localparam logic [7:0] OP_STATUS  = 8'h70;
    localparam logic [7:0] OP_CLEAR   = 8'h50;
    localparam logic [7:0] OP_PGM     = 8'h40;
    localparam logic [7:0] OP_ERASE   = 8'h20;
    localparam logic [7:0] OP_CONFIRM = 8'hD0;
    localparam logic [7:0] OP_SUSPEND = 8'hB0;

endpackage

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BLK_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              eng_busy,
    output cmd_state_t        state,
    output rd_mode_t          mode,
    output logic [1:0]        err,
    output logic              start_pgm,
    output logic              start_ers,
    output logic              abort
);

    cmd_state_t       st_q, st_n;
    rd_mode_t         mode_q, mode_n;
    logic [1:0]       err_q, err_n;
    logic [BLK_W-1:0] blk_q, blk_n;
    logic             last_ff_q, last_ff_n;
    logic             ers_q, ers_n;
    logic [BLK_W-1:0] wr_blk;

    assign wr_blk = addr[ADDR_W-1 -: BLK_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= CMD_READY;
            mode_q    <= RD_ARRAY;
            err_q     <= 2'b00;
            blk_q     <= '0;
            last_ff_q <= 1'b0;
            ers_q     <= 1'b0;
        end else begin
            st_q      <= st_n;
            mode_q    <= mode_n;
            err_q     <= err_n;
            blk_q     <= blk_n;
            last_ff_q <= last_ff_n;
            ers_q     <= ers_n;
        end
    end

    always_comb begin
        st_n      = st_q;
        mode_n    = mode_q;
        err_n     = err_q;
        blk_n     = blk_q;
        ers_n     = ers_q;
        last_ff_n = wr_en ? (wdata == OP_ARRAY) : last_ff_q;
        start_pgm = 1'b0;
        start_ers = 1'b0;
        abort     = 1'b0;

        if (st_q == CMD_RUN && !eng_busy)
            st_n = CMD_READY;

        if (wr_en) begin
            unique case (st_q)
                CMD_READY, CMD_ERS_FAIL: begin
                    if (!(st_q == CMD_ERS_FAIL && wdata == OP_CONFIRM)) begin
                        st_n = CMD_READY;
                        case (wdata)
                            OP_ARRAY:  mode_n = RD_ARRAY;
                            OP_IDENT:  mode_n = RD_IDENT;
                            OP_STATUS: mode_n = RD_STATUS;
                            OP_CLEAR:  err_n  = 2'b00;
                            OP_PGM:    st_n   = CMD_PGM_WAIT;
                            OP_ERASE: begin
                                st_n  = CMD_ERS_WAIT;
                                blk_n = wr_blk;
                            end
                            default: ;
                        endcase
                    end
                end
                CMD_PGM_WAIT: begin
                    start_pgm = 1'b1;
                    ers_n     = 1'b0;
                    st_n      = CMD_RUN;
                    mode_n    = RD_STATUS;
                    last_ff_n = 1'b0;
                end
                CMD_ERS_WAIT: begin
                    mode_n = RD_STATUS;
                    if (wdata == OP_CONFIRM && wr_blk == blk_q) begin
                        start_ers = 1'b1;
                        ers_n     = 1'b1;
                        st_n      = CMD_RUN;
                    end else if (wdata == OP_ARRAY) begin
                        err_n = 2'b11;
                        st_n  = CMD_ERS_FAIL;
                    end else begin
                        err_n[1] = 1'b1;
                        st_n     = CMD_READY;
                    end
                end
                CMD_RUN: begin
                    if (wdata == OP_ARRAY && last_ff_q) begin
                        abort  = 1'b1;
                        st_n   = CMD_READY;
                        mode_n = RD_ARRAY;
                    end else if (wdata == OP_STATUS) begin
                        mode_n = RD_STATUS;
                    end else if (wdata == OP_SUSPEND && ers_q && eng_busy) begin
                        st_n = CMD_SUSP;
                    end
                end
                CMD_SUSP: begin
                    case (wdata)
                        OP_CONFIRM: begin
                            st_n   = CMD_RUN;
                            mode_n = RD_STATUS;
                        end
                        OP_ARRAY:  mode_n = RD_ARRAY;
                        OP_STATUS: mode_n = RD_STATUS;
                        OP_IDENT:  mode_n = RD_IDENT;
                        default: ;
                    endcase
                end
            endcase
        end
    end

    assign state = st_q;
    assign mode  = mode_q;
    assign err   = err_q;

endmodule

// File: rtl/flash_engine.sv
module flash_engine #(
    parameter int ADDR_W   = 6,
    parameter int BLK_W    = 2,
    parameter int BUSY_CYC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_pgm,
    input  logic              start_ers,
    input  logic              abort,
    input  logic              pause,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [7:0]        op_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int SHIFT = ADDR_W - BLK_W;
    localparam int CNT_W = $clog2(BUSY_CYC + 1);

    logic [7:0]        mem [DEPTH];
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] tgt_addr;
    logic [7:0]        tgt_data;
    logic              tgt_ers;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            tgt_addr <= '0;
            tgt_data <= 8'hFF;
            tgt_ers  <= 1'b0;
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= 8'hFF;
        end else if (abort) begin
            cnt <= '0;
        end else if (start_pgm || start_ers) begin
            cnt      <= CNT_W'(BUSY_CYC);
            tgt_addr <= op_addr;
            tgt_data <= op_data;
            tgt_ers  <= start_ers;
        end else if (cnt != '0 && !pause) begin
            cnt <= cnt - 1'b1;
            if (cnt == CNT_W'(1)) begin
                if (tgt_ers) begin
                    for (int i = 0; i < DEPTH; i++)
                        if ((ADDR_W'(i) >> SHIFT) == (tgt_addr >> SHIFT))
                            mem[i] <= 8'hFF;
                end else begin
                    mem[tgt_addr] <= mem[tgt_addr] & tgt_data;
                end
            end
        end
    end

    assign busy    = (cnt != '0);
    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/flash_read_path.sv
module flash_read_path
    import flash_cmd_pkg::*;
#(
    parameter int         ADDR_W   = 6,
    parameter logic [7:0] MFR_CODE = 8'hC7,
    parameter logic [7:0] DEV_CODE = 8'h5E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  rd_mode_t          mode,
    input  logic [7:0]        status,
    input  logic [7:0]        arr_data,
    output logic [7:0]        rdata,
    output logic              rvalid
);

    logic [7:0] sel;

    always_comb begin
        unique case (mode)
            RD_ARRAY:  sel = arr_data;
            RD_STATUS: sel = status;
            RD_IDENT:  sel = addr[0] ? DEV_CODE : MFR_CODE;
            default:   sel = 8'hFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= 8'h00;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_en;
            if (rd_en)
                rdata <= sel;
        end
    end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int         ADDR_W   = 6,
    parameter int         BLK_W    = 2,
    parameter int         BUSY_CYC = 16,
    parameter logic [7:0] MFR_CODE = 8'hC7,
    parameter logic [7:0] DEV_CODE = 8'h5E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              rvalid
);

    cmd_state_t cmd_st;
    rd_mode_t   rd_mode;
    logic [1:0] sr_err;
    logic       start_pgm, start_ers, abort;
    logic       eng_busy, eng_pause;
    logic [7:0] arr_data;
    logic [7:0] status;

    assign eng_pause = (cmd_st == CMD_SUSP);
    assign status    = {~(eng_busy & ~eng_pause), eng_pause, sr_err, 4'b0000};

    flash_cmd_fsm #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .eng_busy(eng_busy), .state(cmd_st), .mode(rd_mode), .err(sr_err),
        .start_pgm(start_pgm), .start_ers(start_ers), .abort(abort)
    );

    flash_engine #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .BUSY_CYC(BUSY_CYC)) u_eng (
        .clk(clk), .rst_n(rst_n), .start_pgm(start_pgm), .start_ers(start_ers),
        .abort(abort), .pause(eng_pause), .op_addr(addr), .op_data(wdata),
        .rd_addr(addr), .rd_data(arr_data), .busy(eng_busy)
    );

    flash_read_path #(.ADDR_W(ADDR_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .mode(rd_mode),
        .status(status), .arr_data(arr_data), .rdata(rdata), .rvalid(rvalid)
    );

endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk
    import flash_cmd_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       rd_en,
    input logic       rvalid,
    input logic       wr_en,
    input logic [7:0] wdata,
    input cmd_state_t st,
    input rd_mode_t   rmode,
    input logic [1:0] err,
    input logic       eng_busy,
    input logic       susp
);

    assert_read_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rvalid);

    assert_start_from_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_busy) |-> $past(wr_en));

    assert_busy_reads_status_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CMD_RUN && eng_busy) |-> rmode == RD_STATUS);

    assert_clear_errors_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CMD_READY && wr_en && wdata == OP_CLEAR) |=> err == 2'b00);

    assert_unconfirmed_erase_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CMD_ERS_WAIT && wr_en && wdata == OP_ARRAY)
            |=> (err == 2'b11 && st == CMD_ERS_FAIL && !eng_busy));

    assert_suspend_over_erase_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(susp) |-> eng_busy);

endmodule

bind flash_cmd_ctrl flash_cmd_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rvalid(rvalid),
    .wr_en(wr_en), .wdata(wdata), .st(cmd_st), .rmode(rd_mode),
    .err(sr_err), .eng_busy(eng_busy), .susp(eng_pause)
);

// File: tb/sim_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_flash_cmd_ctrl;

    localparam int         ADDR_W = 6;
    localparam int         BUSY   = 10;
    localparam logic [7:0] MFR    = 8'hC7;
    localparam logic [7:0] DEV    = 8'h5E;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        wdata = 8'h00;
    logic [7:0]        rdata;
    logic              rvalid;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    flash_cmd_ctrl #(.ADDR_W(ADDR_W), .BLK_W(2), .BUSY_CYC(BUSY),
                     .MFR_CODE(MFR), .DEV_CODE(DEV)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
    );

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    always @(negedge clk) begin
        if (rvalid) begin
            logic [7:0] e;
            string t;
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL unexpected read: got %02h expected none", rdata);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_cmp++;
                if (rdata !== e) begin
                    n_bad++;
                    $display("FAIL %s: got %02h expected %02h", t, rdata, e);
                end
            end
        end
    end

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1: reset state
        rd(6'd5, 8'hFF, "R1 array after reset");
        wr(6'd0, 8'h70);
        rd(6'd0, 8'h80, "R1 R4 status after reset");

        // R5 R7: program then read status while busy and after
        wr(6'd3, 8'h40);
        wr(6'd3, 8'hAA);
        rd(6'd9, 8'h00, "R7 busy status");
        idle(BUSY + 4);
        rd(6'd9, 8'h80, "R7 ready status, still status source");
        wr(6'd0, 8'hFF);
        rd(6'd3, 8'hAA, "R2 R5 programmed byte");
        wr(6'd3, 8'h40);
        wr(6'd3, 8'h0F);
        idle(BUSY + 4);
        wr(6'd0, 8'hFF);
        rd(6'd3, 8'h0A, "R5 AND programming");

        // R3: identifier
        wr(6'd0, 8'h90);
        rd(6'd0, MFR, "R3 ident addr 0");
        rd(6'd1, DEV, "R3 ident addr 1");
        rd(6'd6, MFR, "R3 upper bits ignored even");
        rd(6'd7, DEV, "R3 upper bits ignored odd");

        // R12: unassigned codes no-op
        wr(6'd0, 8'h33);
        wr(6'd0, 8'hD0);
        rd(6'd1, DEV, "R12 mode unchanged");

        // R6: erase block 1
        wr(6'd0, 8'hFF);
        wr(6'd20, 8'h40);
        wr(6'd20, 8'h12);
        idle(BUSY + 4);
        wr(6'd0, 8'hFF);
        rd(6'd20, 8'h12, "R5 block1 byte programmed");
        wr(6'd17, 8'h20);
        wr(6'd30, 8'hD0);
        idle(BUSY + 4);
        wr(6'd0, 8'hFF);
        rd(6'd20, 8'hFF, "R6 block1 erased");
        rd(6'd3, 8'h0A, "R6 block0 untouched");

        // R14 R9: wrong block confirm
        wr(6'd18, 8'h40);
        wr(6'd18, 8'h55);
        idle(BUSY + 4);
        wr(6'd17, 8'h20);
        wr(6'd40, 8'hD0);
        rd(6'd0, 8'hA0, "R14 erase error only");
        wr(6'd0, 8'h50);
        rd(6'd0, 8'h80, "R9 errors cleared");

        // R8: read array in place of confirm
        wr(6'd17, 8'h20);
        wr(6'd17, 8'hFF);
        rd(6'd0, 8'hB0, "R8 both error bits");
        wr(6'd17, 8'hD0);
        rd(6'd0, 8'hB0, "R8 confirm ignored, not busy");
        idle(BUSY + 4);
        wr(6'd0, 8'hFF);
        rd(6'd18, 8'h55, "R8 R14 no erase happened");
        wr(6'd0, 8'h50);

        // R13: commands ignored while busy
        wr(6'd5, 8'h40);
        wr(6'd5, 8'hF0);
        wr(6'd0, 8'h90);
        rd(6'd1, 8'h00, "R13 ident ignored while busy");
        idle(BUSY + 4);
        rd(6'd1, 8'h80, "R13 still status after done");
        wr(6'd0, 8'hFF);
        rd(6'd5, 8'hF0, "R13 program completed");

        // R10: double FF abort
        wr(6'd6, 8'h40);
        wr(6'd6, 8'h00);
        wr(6'd0, 8'hFF);
        wr(6'd0, 8'hFF);
        rd(6'd6, 8'hFF, "R10 array mode, target unchanged");
        wr(6'd0, 8'h70);
        rd(6'd0, 8'h80, "R10 ready after abort");
        idle(BUSY + 4);
        wr(6'd0, 8'hFF);
        rd(6'd6, 8'hFF, "R10 no late program");

        // R11: suspend and resume
        wr(6'd40, 8'h40);
        wr(6'd40, 8'h33);
        idle(BUSY + 4);
        wr(6'd40, 8'h20);
        wr(6'd40, 8'hD0);
        idle(2);
        wr(6'd0, 8'hB0);
        rd(6'd0, 8'hC0, "R11 suspended status");
        idle(BUSY * 3);
        wr(6'd0, 8'hFF);
        rd(6'd40, 8'h33, "R11 erase frozen");
        wr(6'd0, 8'hD0);
        rd(6'd0, 8'h00, "R11 resumed busy");
        idle(BUSY + 4);
        rd(6'd0, 8'h80, "R11 done");
        wr(6'd0, 8'hFF);
        rd(6'd40, 8'hFF, "R11 erase completed");

        idle(4);
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL pending reads: got %0d expected 0", exp_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule